// File: doc/BRIEF.md
# Four-Bit ALU Slice

A purely combinational arithmetic/logic slice that works on two 4-bit operands under an 8-bit control word. Each operand can be forced to zero by its own select, and the right operand can then be bitwise inverted so that subtraction is an addition with an inverted right side and a carry-in of one. The adder carry-in comes from a four-way selector that offers a constant zero, a constant one, or the stored carry supplied on the control word. The result is one of OR, AND, XOR or the adder sum.

Two slices form an 8-bit unit: the upper slice picks the stored-carry option and receives the lower slice's carry-out as its stored carry. Besides the result, the slice drives the adder carry-out (always computed, whatever operation is selected), the most significant bit of each conditioned operand, and a copy of the stored carry, so that a downstream flag stage can derive overflow without seeing the raw operands. The slice has no data stream, so no valid/ready handshake applies; every output follows its inputs within the same cycle.

Top module: `alu_slice`

## Requirements
- R1: With operation field ctrl[1:0] = 00 the result is the bitwise OR of the conditioned operands.
- R2: With ctrl[1:0] = 01 the result is the bitwise AND of the conditioned operands.
- R3: With ctrl[1:0] = 10 the result is the bitwise XOR of the conditioned operands.
- R4: With ctrl[1:0] = 11 the result is the low 4 bits of left + right + carry-in over the conditioned operands.
- R5: When ctrl[4] is 1 the left operand is replaced by zero before any other step; when 0 the external left operand is used.
- R6: When ctrl[5] is 1 the right operand is replaced by zero; when 0 the external right operand is used.
- R7: When ctrl[6] is 1 the right operand is bitwise inverted after zero forcing, so zero forcing with inversion yields all ones.
- R8: The carry-in field ctrl[3:2] selects 00 = 0, 01 = 1, 10 = the stored carry ctrl[7], 11 = 0.
- R9: carry_out is the adder carry-out of left + right + carry-in for every operation code, not only for 11.
- R10: l_msb and r_msb equal the top bit of the conditioned left and right operands (after zero forcing and inversion), and carry_thru equals ctrl[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_opnd | input | 4 | Left operand |
| r_opnd | input | 4 | Right operand |
| ctrl | input | 8 | Control word: [1:0] operation, [3:2] carry-in select, [4] left zero, [5] right zero, [6] right invert, [7] stored carry |
| result | output | 4 | Selected operation result |
| carry_out | output | 1 | Adder carry-out, always computed |
| l_msb | output | 1 | Top bit of conditioned left operand |
| r_msb | output | 1 | Top bit of conditioned right operand |
| carry_thru | output | 1 | Copy of stored carry ctrl[7] |

## Verification
The bench chains two slices into an 8-bit unit and sweeps all 256 control words against operand pairs that include the carry-ripple extremes (0xFF + 0x01, 0x7F + 0x01, 0x80 + 0x80), so a slice that broke the carry chain between halves would show wrong upper bits in the sum. Zero forcing combined with inversion is targeted because a design that inverted before forcing would give zero instead of all ones on the right side. The carry-in code 11 is checked to give zero, which catches a design that treated it as the stored carry, and carry-out is compared for logic operations too, which catches a design that gated it by the add code. The pass-through sign bits are compared after inversion, so a design tapping the raw operand would disagree on every subtraction.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  localparam int CTRL_W      = 8;
  localparam int OP_LSB      = 0;
  localparam int CISEL_LSB   = 2;
  localparam int ZERO_L_BIT  = 4;
  localparam int ZERO_R_BIT  = 5;
  localparam int INV_R_BIT   = 6;
  localparam int STORED_BIT  = 7;

  typedef enum logic [1:0] {
    OP_OR  = 2'b00,
    OP_AND = 2'b01,
    OP_XOR = 2'b10,
    OP_ADD = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    CI_ZERO     = 2'b00,
    CI_ONE      = 2'b01,
    CI_STORED   = 2'b10,
    CI_ZERO_ALT = 2'b11
  } cisel_e;

  typedef struct packed {
    logic    stored;
    logic    inv_r;
    logic    zero_r;
    logic    zero_l;
    cisel_e  cisel;
    alu_op_e op;
  } ctrl_t;

endpackage

// File: rtl/alu_slice_opnd.sv
module alu_slice_opnd #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] d,
  input  logic             force_zero,
  input  logic             invert,
  output logic [WIDTH-1:0] q
);
  // zero forcing first, then optional inversion, bit by bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic gated;
    assign gated = d[i] & ~force_zero;
    assign q[i]  = gated ^ invert;
  end
endmodule

// File: rtl/alu_slice_cimux.sv
module alu_slice_cimux
  import alu_slice_pkg::*;
(
  input  cisel_e sel,
  input  logic   stored,
  output logic   ci
);
  always_comb begin
    unique case (sel)
      CI_ONE:    ci = 1'b1;
      CI_STORED: ci = stored;
      default:   ci = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_slice_adder.sv
module alu_slice_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] sum,
  output logic             co
);
  logic [WIDTH:0] chain;
  assign chain[0] = ci;

  // ripple chain of full adders
  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic p;
    assign p          = a[i] ^ b[i];
    assign sum[i]     = p ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (p & chain[i]);
  end

  assign co = chain[WIDTH];
endmodule

// File: rtl/alu_slice_logic.sv
module alu_slice_logic
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] sum,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (op)
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      default: y = sum;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]  l_opnd,
  input  logic [WIDTH-1:0]  r_opnd,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out,
  output logic              l_msb,
  output logic              r_msb,
  output logic              carry_thru
);
  localparam int MSB = WIDTH - 1;

  ctrl_t            cw;
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             ci;

  assign cw = ctrl_t'(ctrl);

  alu_slice_opnd #(.WIDTH(WIDTH)) u_left (
    .d          (l_opnd),
    .force_zero (cw.zero_l),
    .invert     (1'b0),
    .q          (a_eff)
  );

  alu_slice_opnd #(.WIDTH(WIDTH)) u_right (
    .d          (r_opnd),
    .force_zero (cw.zero_r),
    .invert     (cw.inv_r),
    .q          (b_eff)
  );

  alu_slice_cimux u_cimux (
    .sel    (cw.cisel),
    .stored (cw.stored),
    .ci     (ci)
  );

  alu_slice_adder #(.WIDTH(WIDTH)) u_add (
    .a   (a_eff),
    .b   (b_eff),
    .ci  (ci),
    .sum (sum),
    .co  (carry_out)
  );

  alu_slice_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (a_eff),
    .b   (b_eff),
    .sum (sum),
    .op  (cw.op),
    .y   (result)
  );

  // sign bits for the downstream overflow logic, taken after conditioning
  assign l_msb      = a_eff[MSB];
  assign r_msb      = b_eff[MSB];
  assign carry_thru = cw.stored;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0]  l_opnd,
  input logic [WIDTH-1:0]  a_eff,
  input logic [WIDTH-1:0]  b_eff,
  input logic [CTRL_W-1:0] ctrl,
  input logic [WIDTH-1:0]  result,
  input logic              carry_out,
  input logic              l_msb,
  input logic              r_msb,
  input logic              carry_thru
);
  localparam logic [WIDTH-1:0] ONES = '1;

  always_comb begin
    if (ctrl[1:0] == 2'b00)
      p_or_r1: assert (result == (a_eff | b_eff)) else $error("R1 OR mismatch");
    if (ctrl[1:0] == 2'b01)
      p_and_r2: assert (result == (a_eff & b_eff)) else $error("R2 AND mismatch");
    if (ctrl[1:0] == 2'b10)
      p_xor_r3: assert (result == (a_eff ^ b_eff)) else $error("R3 XOR mismatch");
    if (!ctrl[ZERO_L_BIT])
      p_left_pass_r5: assert (a_eff == l_opnd) else $error("R5 left not passed");
    if (ctrl[ZERO_L_BIT])
      p_left_zero_r5: assert (l_msb == 1'b0 && a_eff == '0) else $error("R5 left not zero");
    if (ctrl[ZERO_R_BIT] && !ctrl[INV_R_BIT])
      p_right_zero_r6: assert (r_msb == 1'b0 && b_eff == '0) else $error("R6 right not zero");
    if (ctrl[ZERO_R_BIT] && ctrl[INV_R_BIT])
      p_right_ones_r7: assert (r_msb == 1'b1 && b_eff == ONES) else $error("R7 order wrong");
    if (ctrl[1:0] == 2'b11 && ctrl[ZERO_L_BIT] && ctrl[ZERO_R_BIT] && !ctrl[INV_R_BIT])
      p_cisel_r8: assert (result == WIDTH'(ctrl[3:2] == 2'b01 ||
                                         (ctrl[3:2] == 2'b10 && ctrl[STORED_BIT])))
        else $error("R8 carry-in select wrong");
    if (ctrl[1:0] != 2'b11 && ctrl[ZERO_L_BIT] && ctrl[ZERO_R_BIT] && ctrl[INV_R_BIT]
        && ctrl[3:2] == 2'b01)
      p_cout_logic_r9: assert (carry_out == 1'b1) else $error("R9 carry-out gated");
    p_carry_thru_r10: assert (carry_thru == ctrl[STORED_BIT]) else $error("R10 carry copy");
  end
endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .l_opnd     (l_opnd),
  .a_eff      (a_eff),
  .b_eff      (b_eff),
  .ctrl       (ctrl),
  .result     (result),
  .carry_out  (carry_out),
  .l_msb      (l_msb),
  .r_msb      (r_msb),
  .carry_thru (carry_thru)
);

// File: tb/alu_slice_tb.sv
module alu_slice_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [7:0] l8, r8, ctl;
  logic [3:0] lo_y, hi_y;
  logic       lo_co, hi_co, lo_lm, lo_rm, hi_lm, hi_rm, lo_ct, hi_ct;
  logic [7:0] hi_ctl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // upper slice takes the stored-carry option fed by the lower carry-out
  assign hi_ctl = {lo_co, ctl[6:4], 2'b10, ctl[1:0]};

  alu_slice u_dut (
    .l_opnd(l8[3:0]), .r_opnd(r8[3:0]), .ctrl(ctl),
    .result(lo_y), .carry_out(lo_co), .l_msb(lo_lm), .r_msb(lo_rm), .carry_thru(lo_ct)
  );
  alu_slice u_hi (
    .l_opnd(l8[7:4]), .r_opnd(r8[7:4]), .ctrl(hi_ctl),
    .result(hi_y), .carry_out(hi_co), .l_msb(hi_lm), .r_msb(hi_rm), .carry_thru(hi_ct)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (ctl=%02h l=%02h r=%02h)",
               tag, act, exp, ctl, l8, r8);
    end
  endtask

  // behavioural reference on integers
  task automatic apply(input logic [7:0] c, input logic [7:0] l, input logic [7:0] r,
                       input string extra);
    int a, b, ci, s, y;
    string tag;
    @(posedge clk);
    #1;
    ctl = c; l8 = l; r8 = r;
    @(negedge clk);
    a  = c[4] ? 0 : int'(l);
    b  = c[5] ? 0 : int'(r);
    if (c[6]) b = (~b) & 8'hFF;
    case (c[3:2])
      2'b01:   ci = 1;
      2'b10:   ci = int'(c[7]);
      default: ci = 0;
    endcase
    s = a + b + ci;
    case (c[1:0])
      2'b00: begin y = a | b; tag = "R1"; end
      2'b01: begin y = a & b; tag = "R2"; end
      2'b10: begin y = a ^ b; tag = "R3"; end
      default: begin y = s & 8'hFF; tag = "R4"; end
    endcase
    if (extra != "") tag = extra;
    check(tag, int'({hi_y, lo_y}), y);
    check("R9 carry_out", int'(hi_co), (s >> 8) & 1);
    check("R10 pass", int'({hi_lm, hi_rm, lo_ct}),
          (((a >> 7) & 1) << 2) | (((b >> 7) & 1) << 1) | int'(c[7]));
  endtask

  function automatic logic [7:0] pat(input int k, input int c, input bit right);
    case (k)
      0: return 8'h00;
      1: return right ? 8'h01 : 8'hFF;
      2: return 8'h80;
      3: return right ? 8'h01 : 8'h7F;
      4: return right ? 8'h0F : 8'hF0;
      default: return 8'((k * 37 + c * 11 + (right ? 91 : 5)) & 8'hFF);
    endcase
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    ctl = 8'h00; l8 = 8'h00; r8 = 8'h00;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state: zero control and operands gives zero everywhere
    check("R1 idle result", int'({hi_y, lo_y}), 0);
    check("R9 idle carry", int'(hi_co), 0);

    // R5: left forced to zero, OR with zero right gives zero
    apply(8'h30, 8'hFF, 8'hAA, "R5 left zero");
    // R6: right forced to zero, OR passes the left operand
    apply(8'h20, 8'h5A, 8'hFF, "R6 right zero");
    // R7: zero then invert on the right gives all ones, AND passes left
    apply(8'h61, 8'h5A, 8'h00, "R7 zero-then-invert");
    // R8: each carry-in code with both operands zeroed under ADD
    apply(8'h33, 8'h12, 8'h34, "R8 cisel 00");
    apply(8'h37, 8'h12, 8'h34, "R8 cisel 01");
    apply(8'hBB, 8'h12, 8'h34, "R8 cisel 10 stored=1");
    apply(8'h3B, 8'h12, 8'h34, "R8 cisel 10 stored=0");
    apply(8'hBF, 8'h12, 8'h34, "R8 cisel 11");
    // R4: subtraction 0x10 - 0x01 = 0x0F via invert and carry-in one
    apply(8'h47, 8'h10, 8'h01, "R4 subtract");

    // full sweep of control words over operand patterns
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < 8; k++) begin
        apply(8'(c), pat(k, c, 1'b0), pat(k, c, 1'b1), "");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule